// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between the execute stage of a processor and a data memory that is one word wide and addressed in bytes. For each memory request it adds a base register value to a signed 16-bit displacement to form the effective byte address. It then derives the word-aligned address presented to the memory. For stores it moves the byte, halfword or word to the correct byte lanes and raises the matching byte enables. For loads it picks the addressed byte or halfword out of the returned word and widens it to a full word.

Byte lanes follow big-endian order: the lowest byte address within a word maps to the most significant byte of the word. Subword loads are sign-extended unless the request asks for zero extension. A halfword must sit on a 2-byte boundary and a word on a 4-byte boundary. A request that breaks this rule raises a misalignment flag, and the unit issues no memory access for it.

The request side is a valid-only stream with no back-pressure. A request is taken in any cycle where `req_valid` is high, and the memory is assumed to take every access in that same cycle. The unit holds no state. The store steering and the load result both settle within the same cycle as their inputs, so load data appears in the cycle the memory read data arrives.

Top module: `be_lsu_align`

## Requirements
- R1: The effective address is `base_addr` plus `offset` sign-extended to 32 bits. `mem_addr` equals that address with its two low bits forced to zero.
- R2: `req_size` encodes the access width as follows: 00 is a byte, 01 is a halfword, and 10 or 11 is a word. `misalign` is high exactly when `req_valid` is high and one of these holds: the access is a halfword and address bit 0 is 1, or the access is a word and address bits 1:0 are not 00.
- R3: `mem_wr_en` is high only for a valid, aligned store (`req_store`=1). `mem_rd_en` is high only for a valid, aligned load (`req_store`=0). A misaligned store leaves memory unchanged.
- R4: `mem_be` bit 3 stands for the lowest byte address of the word. The enables depend on the access and its byte offset k within the word:
  - a byte at offset k gives bit 3-k only;
  - a halfword at offset 0 gives 1100;
  - a halfword at offset 2 gives 0011;
  - a word gives 1111.
  `mem_be` is 0000 whenever `mem_wr_en` is low.
- R5: On a store, `mem_wdata` is formed as follows:
  - a byte store puts `store_data[7:0]` on bits 31-8k down to 24-8k and zeros on the other bits;
  - a halfword store puts `store_data[15:0]` on bits 31:16 at offset 0, or on bits 15:0 at offset 2;
  - a word store passes `store_data` through unchanged.
- R6: On a load, the addressed byte is taken from `mem_rdata` bits 31-8k down to 24-8k. A halfword is taken from bits 31:16 at offset 0 and from bits 15:0 at offset 2. A word is `mem_rdata` as is.
- R7: When `req_unsigned` is 0, a byte or halfword load fills the upper bits with copies of its top bit. When `req_unsigned` is 1, they are filled with zeros. Word loads are not affected by `req_unsigned`.
- R8: `load_data` follows `mem_rdata` in the same cycle, with no register in between. `load_data` is zero whenever `mem_rd_en` is low.
- R9: While `req_valid` is low, `mem_wr_en`, `mem_rd_en`, `misalign`, `mem_be` and `load_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width: 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Zero-extend subword loads when 1 |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed byte displacement |
| store_data | input | 32 | Store value, right-justified |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_be | output | 4 | Byte enables, bit 3 = lowest address |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Word returned by memory |
| load_data | output | 32 | Extracted and extended load value |
| misalign | output | 1 | Misaligned access flag |

## Verification
A word written with distinct bytes is read back with byte loads at each of the four offsets, which tells big-endian lane order apart from little-endian order. Byte and halfword loads whose top bit is set are issued twice, once signed and once unsigned, to separate sign extension from zero extension. The largest positive and most negative displacements, and base values that carry across bit 15, show whether the offset is sign-extended before the add. Misaligned stores are each followed by a word load of the same location, which proves that the write was suppressed and not merely flagged.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE     = 2'b00,
    SZ_HALF     = 2'b01,
    SZ_WORD     = 2'b10,
    SZ_WORD_ALT = 2'b11
  } acc_size_e;
endpackage

// File: rtl/be_ea_calc.sv
module be_ea_calc #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LSB_W  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  disp,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] word_addr,
  output logic [LSB_W-1:0]  lane_off,
  output logic              bad_align
);
  import lsu_align_pkg::*;

  logic [ADDR_W-1:0] ea;

  assign ea        = base + {{(ADDR_W-OFF_W){disp[OFF_W-1]}}, disp};
  assign lane_off  = ea[LSB_W-1:0];
  assign word_addr = {ea[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};

  always_comb begin
    case (size)
      SZ_BYTE: bad_align = 1'b0;
      SZ_HALF: bad_align = ea[0];
      default: bad_align = |ea[LSB_W-1:0];
    endcase
  end
endmodule

// File: rtl/be_store_lanes.sv
module be_store_lanes #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES)
) (
  input  logic              en,
  input  logic [1:0]        size,
  input  logic [LSB_W-1:0]  lane_off,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata_out
);
  import lsu_align_pkg::*;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic       hit;
    logic [7:0] lane_byte;

    always_comb begin
      hit       = 1'b0;
      lane_byte = '0;
      case (size)
        SZ_BYTE: begin
          if (lane_off == LSB_W'(j)) begin
            hit       = 1'b1;
            lane_byte = wdata_in[7:0];
          end
        end
        SZ_HALF: begin
          if (lane_off == LSB_W'(j)) begin
            hit       = 1'b1;
            lane_byte = wdata_in[15:8];
          end else if ((lane_off + LSB_W'(1)) == LSB_W'(j)) begin
            hit       = 1'b1;
            lane_byte = wdata_in[7:0];
          end
        end
        default: begin
          hit       = 1'b1;
          lane_byte = wdata_in[DATA_W-1-8*j -: 8];
        end
      endcase
    end

    assign be[LANES-1-j]                 = en & hit;
    assign wdata_out[DATA_W-1-8*j -: 8] = (en & hit) ? lane_byte : 8'h00;
  end
endmodule

// File: rtl/be_load_extract.sv
module be_load_extract #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES)
) (
  input  logic              en,
  input  logic [1:0]        size,
  input  logic              zero_ext,
  input  logic [LSB_W-1:0]  lane_off,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ldata
);
  import lsu_align_pkg::*;

  logic [7:0] lane [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_split
    assign lane[j] = rdata[DATA_W-1-8*j -: 8];
  end

  logic [7:0]  b_val;
  logic [15:0] h_val;

  assign b_val = lane[lane_off];
  assign h_val = {lane[lane_off], lane[lane_off + LSB_W'(1)]};

  always_comb begin
    ldata = '0;
    if (en) begin
      case (size)
        SZ_BYTE: ldata = {{(DATA_W-8){~zero_ext & b_val[7]}}, b_val};
        SZ_HALF: ldata = {{(DATA_W-16){~zero_ext & h_val[15]}}, h_val};
        default: ldata = rdata;
      endcase
    end
  end
endmodule

// File: rtl/be_lsu_align.sv
module be_lsu_align #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES)
) (
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] store_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr_en,
  output logic              mem_rd_en,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] load_data,
  output logic              misalign
);
  import lsu_align_pkg::*;

  logic [LSB_W-1:0] lane_off;
  logic             bad_align;

  be_ea_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LSB_W(LSB_W)) u_ea (
    .base      (base_addr),
    .disp      (offset),
    .size      (req_size),
    .word_addr (mem_addr),
    .lane_off  (lane_off),
    .bad_align (bad_align)
  );

  assign misalign  = req_valid & bad_align;
  assign mem_wr_en = req_valid & req_store & ~bad_align;
  assign mem_rd_en = req_valid & ~req_store & ~bad_align;

  be_store_lanes #(.DATA_W(DATA_W)) u_st (
    .en        (mem_wr_en),
    .size      (req_size),
    .lane_off  (lane_off),
    .wdata_in  (store_data),
    .be        (mem_be),
    .wdata_out (mem_wdata)
  );

  be_load_extract #(.DATA_W(DATA_W)) u_ld (
    .en       (mem_rd_en),
    .size     (req_size),
    .zero_ext (req_unsigned),
    .lane_off (lane_off),
    .rdata    (mem_rdata),
    .ldata    (load_data)
  );

  always_comb begin
    if (misalign) begin
      p_no_access_on_misalign_r3: assert (!mem_wr_en && !mem_rd_en)
        else $error("access issued on misaligned request");
    end
    if (!mem_wr_en) begin
      p_be_idle_r4: assert (mem_be == '0)
        else $error("byte enables active without write");
    end
    if (mem_wr_en && req_size == SZ_BYTE) begin
      p_byte_one_lane_r4: assert ($countones(mem_be) == 1)
        else $error("byte store must enable one lane");
    end
    if (mem_wr_en && req_size[1]) begin
      p_word_passthru_r5: assert (mem_wdata == store_data && mem_be == '1)
        else $error("word store altered data or enables");
    end
    if (!mem_rd_en) begin
      p_load_quiet_r8: assert (load_data == '0)
        else $error("load data nonzero without read");
    end
  end
endmodule

// File: tb/be_lsu_align_tb.sv
module be_lsu_align_tb;
  logic        clk = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] base_addr = '0, store_data = '0;
  logic [15:0] offset = '0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, load_data;
  logic        mem_wr_en, mem_rd_en, misalign;
  logic [3:0]  mem_be;

  int tests = 0;
  int fails = 0;

  logic [31:0] wmem [0:63];
  logic [7:0]  bmem [0:255];

  always #10 clk = ~clk;

  be_lsu_align u_dut (
    .req_valid(req_valid), .req_store(req_store), .req_size(req_size),
    .req_unsigned(req_unsigned), .base_addr(base_addr), .offset(offset),
    .store_data(store_data), .mem_addr(mem_addr), .mem_wr_en(mem_wr_en),
    .mem_rd_en(mem_rd_en), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .load_data(load_data), .misalign(misalign)
  );

  assign mem_rdata = wmem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (mem_wr_en) begin
      for (int j = 0; j < 4; j++)
        if (mem_be[3-j]) wmem[mem_addr[7:2]][31-8*j -: 8] <= mem_wdata[31-8*j -: 8];
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit st, input logic [1:0] sz, input bit uns,
                        input logic [31:0] base, input logic [15:0] off,
                        input logic [31:0] d);
    logic [31:0] ea, exp_w, exp_ld;
    logic [3:0]  exp_be;
    logic [7:0]  a;
    logic [1:0]  k;
    bit          mis;
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
    base_addr = base; offset = off; store_data = d;
    #2;
    ea = base + {{16{off[15]}}, off};
    a  = ea[7:0];
    k  = ea[1:0];
    mis = (sz == 2'b01) ? ea[0] : (sz[1] ? (k != 2'b00) : 1'b0);
    chk(mem_addr, {ea[31:2], 2'b00}, "R1 addr");
    chk({31'd0, misalign}, {31'd0, mis}, "R2 misalign");
    chk({31'd0, mem_wr_en}, {31'd0, st & ~mis}, "R3 wr_en");
    chk({31'd0, mem_rd_en}, {31'd0, ~st & ~mis}, "R3 rd_en");
    exp_be = 4'b0000; exp_w = 32'h0;
    if (st && !mis) begin
      if (sz == 2'b00) begin exp_be = 4'b1000 >> k; exp_w = {24'h0, d[7:0]} << (8*(3-k)); end
      else if (sz == 2'b01) begin exp_be = 4'b1100 >> k; exp_w = {16'h0, d[15:0]} << (8*(2-k)); end
      else begin exp_be = 4'b1111; exp_w = d; end
      chk(mem_wdata, exp_w, "R5 wdata");
    end
    chk({28'd0, mem_be}, {28'd0, exp_be}, "R4 be");
    exp_ld = 32'h0;
    if (!st && !mis) begin
      if (sz == 2'b00) exp_ld = {{24{~uns & bmem[a][7]}}, bmem[a]};
      else if (sz == 2'b01) exp_ld = {{16{~uns & bmem[a][7]}}, bmem[a], bmem[8'(a+1)]};
      else exp_ld = {bmem[a], bmem[8'(a+1)], bmem[8'(a+2)], bmem[8'(a+3)]};
    end
    chk(load_data, exp_ld, (sz == 2'b00 || sz == 2'b01) ? "R6 R7 R8 load" : "R6 R8 load");
    @(posedge clk);
    if (st && !mis) begin
      if (sz == 2'b00) bmem[a] = d[7:0];
      else if (sz == 2'b01) begin bmem[a] = d[15:8]; bmem[8'(a+1)] = d[7:0]; end
      else begin
        bmem[a] = d[31:24]; bmem[8'(a+1)] = d[23:16];
        bmem[8'(a+2)] = d[15:8]; bmem[8'(a+3)] = d[7:0];
      end
    end
  endtask

  localparam logic [31:0] B = 32'h0000_2000;

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 64; i++) wmem[i] = {bmem[4*i], bmem[4*i+1], bmem[4*i+2], bmem[4*i+3]};

    @(negedge clk); #2;
    chk({31'd0, mem_wr_en}, 32'd0, "R9 idle wr_en");
    chk({31'd0, mem_rd_en}, 32'd0, "R9 idle rd_en");
    chk({31'd0, misalign}, 32'd0, "R9 idle misalign");
    chk({28'd0, mem_be}, 32'd0, "R9 idle be");
    chk(load_data, 32'd0, "R9 idle load");

    // R6 big-endian lane order from a known word
    run_op(1, 2'b10, 0, B, 16'h0010, 32'h1234_5678);
    run_op(0, 2'b00, 1, B, 16'h0010, 0);
    run_op(0, 2'b00, 0, B, 16'h0013, 0);
    run_op(0, 2'b01, 0, B, 16'h0012, 0);
    chk(load_data, 32'h0000_5678, "R6 half lane");

    // R7 sign vs zero extension
    run_op(1, 2'b00, 0, B, 16'h0021, 32'hFFFF_FF80);
    run_op(0, 2'b00, 0, B, 16'h0021, 0);
    run_op(0, 2'b00, 1, B, 16'h0021, 0);
    run_op(1, 2'b01, 0, B, 16'h0032, 32'h0000_BEEF);
    run_op(0, 2'b01, 0, B, 16'h0032, 0);
    run_op(0, 2'b01, 1, B, 16'h0032, 0);
    run_op(1, 2'b01, 0, B, 16'h0030, 32'h0000_8001);
    run_op(0, 2'b10, 1, B, 16'h0030, 0);
    run_op(0, 2'b10, 0, B, 16'h0030, 0);

    // R3 misaligned stores leave memory alone
    run_op(1, 2'b10, 0, B, 16'h0041, 32'hDEAD_BEEF);
    run_op(1, 2'b11, 0, B, 16'h0042, 32'hDEAD_BEEF);
    run_op(1, 2'b01, 0, B, 16'h0043, 32'hDEAD_BEEF);
    run_op(0, 2'b10, 0, B, 16'h0040, 0);
    run_op(0, 2'b01, 0, B, 16'h0043, 0);
    run_op(0, 2'b10, 0, B, 16'h0046, 0);

    // R1 offset extremes and carries
    run_op(0, 2'b10, 0, 32'h0001_0000, 16'h8000, 0);
    run_op(0, 2'b00, 0, 32'h0000_1F00, 16'h7FFF, 0);
    run_op(0, 2'b10, 0, 32'h0000_2100, 16'hFFFC, 0);
    run_op(1, 2'b11, 0, 32'h0000_20FF, 16'h0001, 32'hA5C3_0F96);
    run_op(0, 2'b10, 0, 32'h0000_2104, 16'hFFFC, 0);

    // R4 R5 every byte lane and both halfword lanes
    for (int k = 0; k < 4; k++) begin
      run_op(1, 2'b00, 0, B, 16'(16'h0050 + k), 32'(8'hF0 + k));
      run_op(0, 2'b00, 0, B, 16'(16'h0050 + k), 0);
    end
    run_op(0, 2'b10, 0, B, 16'h0050, 0);
    run_op(1, 2'b01, 0, B, 16'h0062, 32'h0000_7A11);
    run_op(1, 2'b01, 0, B, 16'h0060, 32'h0000_C3D4);
    run_op(0, 2'b10, 0, B, 16'h0060, 0);

    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b1;
    #2;
    chk({31'd0, mem_wr_en}, 32'd0, "R9 drop valid");
    chk({28'd0, mem_be}, 32'd0, "R9 be after drop");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule